// File: doc/BRIEF.md
# Dual-Mode Decade Divider Counter

This block is a synchronous counter built from two sections: a modulo-2 stage whose single output is `qa_o`, and a modulo-5 stage whose three outputs are `qd_o`, `qc_o` and `qb_o`, with `qd_o` as the most significant bit. Each section has its own count input. Both count inputs are synchronized to `clk_i` and edge-detected there. A high-to-low transition on a count input advances its section. Rising transitions never advance anything.

A two-bit mode, captured once after each reset, selects how the two sections are wired.
- In split mode the sections count on their own inputs.
- In decimal mode the falling edge of `qa_o` drives the modulo-5 stage, so `{qd_o,qc_o,qb_o,qa_o}` counts 0 to 9 in binary.
- In two-five mode the falling edge of `qd_o` drives the modulo-2 stage. This makes `qa_o` a square wave with a 50% duty cycle at one tenth of the input rate.

A registered flag pulses for one clock whenever a chained count wraps from 9 to 0. The chained stage moves one clock after the stage that drives it, so a single intermediate value is visible for one clock at each carry. The flag is glitch-free and is the signal intended for decoding.

Top module: `dual_decade_div`

## Requirements
- R1: While `rst_ni` is low, all of `qa_o`, `qb_o`, `qc_o`, `qd_o` and `tc_o` are 0 and no count input changes any of them.
- R2: In split mode, `qa_o` toggles once for every high-to-low transition of `cnt_a_i`. The new value appears after the second rising clock edge following the first edge that samples the low level. Rising transitions have no effect.
- R3: In split mode, `{qd_o,qc_o,qb_o}` steps 000, 001, 010, 011, 100 and then back to 000 on each high-to-low transition of `cnt_b_i`, with the same latency as R2.
- R4: In decimal mode (`mode_i` = 2'b01), the modulo-5 stage advances one clock after `qa_o` falls, and `cnt_b_i` is ignored. `{qd_o,qc_o,qb_o,qa_o}` counts 0000 to 1001 and then returns to 0000.
- R5: In two-five mode (`mode_i` = 2'b10), `qa_o` toggles one clock after `qd_o` falls, and `cnt_a_i` is ignored. `{qa_o,qd_o,qc_o,qb_o}` runs 0000, 0001, 0010, 0011, 0100, 1000, 1001, 1010, 1011, 1100 and then back to 0000.
- R6: `tc_o` is high for exactly one clock, in the first clock in which a chained count reads 0 after count 9. It stays low in split mode.
- R7: `mode_i` = 2'b11 behaves exactly as split mode.
- R8: `mode_i` is sampled on the first clock edge after `rst_ni` rises. Later changes have no effect until the next reset.
- R9: A count input that is already low when reset is released is not counted as a falling edge. Only a later high-to-low transition advances the section.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_a_i | input | 1 | Count input of the modulo-2 stage (asynchronous) |
| cnt_b_i | input | 1 | Count input of the modulo-5 stage (asynchronous) |
| mode_i | input | 2 | 00 split, 01 decimal, 10 two-five, 11 split |
| qa_o | output | 1 | Modulo-2 stage output |
| qb_o | output | 1 | Modulo-5 stage bit 0 |
| qc_o | output | 1 | Modulo-5 stage bit 1 |
| qd_o | output | 1 | Modulo-5 stage bit 2 (MSB) |
| tc_o | output | 1 | One-clock pulse on a chained 9-to-0 wrap |

## Verification
The assertions assume that each count-input level lasts at least one full clock, so that a pulse is never shorter than the sampling period. They also assume that `mode_i` only matters on the first clock after reset. The stimulus changes inputs only on falling clock edges and holds every low and high level for at least one clock, with hold times varied from one to four clocks. It also changes `mode_i` mid-run, to show that such a change is ignored. Reset is asserted both while a count input is low and while inputs toggle, which covers the blocking and edge-suppression rules.

// File: rtl/dec_div_pkg.sv
package dec_div_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_DEC   = 2'b01,
    MODE_BIQ   = 2'b10,
    MODE_ALIAS = 2'b11
  } div_mode_e;

  // Reserved code folds onto split operation
  function automatic div_mode_e decode_mode(logic [1:0] raw);
    return (raw == 2'b11) ? MODE_SPLIT : div_mode_e'(raw);
  endfunction
endpackage

// File: rtl/dd_fall_detect.sv
module dd_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[STAGES-2:0], in_i};
      prev_q   <= sync_q[STAGES-1];
      primed_q <= 1'b1;
    end
  end

  // first cycle after reset never yields an edge
  assign fall_o = primed_q & prev_q & ~sync_q[STAGES-1];

  // edge pulse feeding R2 and R3 lasts a single clock
  assert_fall_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dd_div2.sv
module dd_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (adv_i) q_q <= ~q_q;
  end

  assign q_o = q_q;

  assert_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (q_o != $past(q_o)));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(q_o));
endmodule

// File: rtl/dd_div5.sv
module dd_div5 #(
  parameter int unsigned MOD = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       adv_i,
  output logic [$clog2(MOD)-1:0]     q_o,
  output logic                       wrap_o
);
  localparam int unsigned W    = $clog2(MOD);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] cnt_q;

  assign wrap_o = adv_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign q_o = cnt_q;

  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && q_o == LAST) |=> (q_o == '0));
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && q_o != LAST) |=> (q_o == $past(q_o) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(q_o));
endmodule

// File: rtl/dual_decade_div.sv
module dual_decade_div
  import dec_div_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cnt_a_i,
  input  logic       cnt_b_i,
  input  logic [1:0] mode_i,
  output logic       qa_o,
  output logic       qb_o,
  output logic       qc_o,
  output logic       qd_o,
  output logic       tc_o
);
  localparam int unsigned QUIN = 5;
  localparam int unsigned QW   = $clog2(QUIN);

  div_mode_e       mode_q;
  logic            cfg_q;
  logic            fall_a, fall_b;
  logic            adv2, adv5, wrap5;
  logic            qa, qd;
  logic [QW-1:0]   q5;
  logic            qa_prev_q, qd_prev_q;
  logic            qa_fall, qd_fall;
  logic            tc_q;

  // mode is captured once per reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SPLIT;
      cfg_q  <= 1'b0;
    end else if (!cfg_q) begin
      mode_q <= decode_mode(mode_i);
      cfg_q  <= 1'b1;
    end
  end

  dd_fall_detect #(.STAGES(SYNC_STAGES)) u_fall_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(cnt_a_i), .fall_o(fall_a));
  dd_fall_detect #(.STAGES(SYNC_STAGES)) u_fall_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(cnt_b_i), .fall_o(fall_b));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qa_prev_q <= 1'b0;
      qd_prev_q <= 1'b0;
    end else begin
      qa_prev_q <= qa;
      qd_prev_q <= qd;
    end
  end

  assign qa_fall = qa_prev_q & ~qa;
  assign qd_fall = qd_prev_q & ~qd;

  assign adv2 = (mode_q == MODE_BIQ) ? qd_fall : fall_a;
  assign adv5 = (mode_q == MODE_DEC) ? qa_fall : fall_b;

  dd_div2 u_div2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv2), .q_o(qa));

  dd_div5 #(.MOD(QUIN)) u_div5 (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv5), .q_o(q5), .wrap_o(wrap5));

  assign qd = q5[QW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tc_q <= 1'b0;
    else         tc_q <= ((mode_q == MODE_DEC) && wrap5) ||
                         ((mode_q == MODE_BIQ) && adv2 && qa);
  end

  assign qa_o = qa;
  assign qb_o = q5[0];
  assign qc_o = q5[1];
  assign qd_o = qd;
  assign tc_o = tc_q;

  assert_mode_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q |=> $stable(mode_q));
  assert_dec_chain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DEC && !(qa_prev_q && !qa_o)) |=> $stable({qd_o, qc_o, qb_o}));
  assert_biq_chain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BIQ && !(qd_prev_q && !qd_o)) |=> $stable(qa_o));
  assert_tc_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o);
  assert_tc_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> ({qd_o, qc_o, qb_o, qa_o} == 4'b0000));
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> ({qa_o, qb_o, qc_o, qd_o, tc_o} == 5'b0));
endmodule

// File: tb/sim_dual_decade_div.sv
`timescale 1ns/1ps
module sim_dual_decade_div;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cnt_a = 1'b1, cnt_b = 1'b1;
  logic [1:0] mode = 2'b00;
  logic qa, qb, qc, qd, tc;

  int n_chk = 0, n_bad = 0, tc_seen = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_decade_div u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .mode_i(mode), .qa_o(qa), .qb_o(qb), .qc_o(qc), .qd_o(qd), .tc_o(tc));

  // behavioural reference: input histories, integer counters
  int ha[3], hb[3];
  int m_qa, m_c5, m_tc, m_mode, m_cfg, m_qa_prev, m_qd_prev;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) begin ha[i] = 0; hb[i] = 0; end
      m_qa = 0; m_c5 = 0; m_tc = 0; m_mode = 0; m_cfg = 0;
      m_qa_prev = 0; m_qd_prev = 0;
    end else begin
      int fa, fb, a2, a5, qaf, qdf;
      fa  = (ha[2] == 1 && ha[1] == 0);
      fb  = (hb[2] == 1 && hb[1] == 0);
      qaf = (m_qa_prev == 1 && m_qa == 0);
      qdf = (m_qd_prev == 1 && m_c5 != 4);
      a2  = (m_mode == 2) ? qdf : fa;
      a5  = (m_mode == 1) ? qaf : fb;
      m_tc = ((m_mode == 1 && a5 && m_c5 == 4) || (m_mode == 2 && a2 && m_qa == 1)) ? 1 : 0;
      m_qa_prev = m_qa;
      m_qd_prev = (m_c5 == 4) ? 1 : 0;
      if (a2) m_qa = 1 - m_qa;
      if (a5) m_c5 = (m_c5 + 1) % 5;
      ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = cnt_a;
      hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = cnt_b;
      if (!m_cfg) begin m_mode = (mode == 2'b11) ? 0 : int'(mode); m_cfg = 1; end
    end
  end

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (!finished) begin
      string t;
      t = (m_mode == 1) ? "R4" : (m_mode == 2) ? "R5" : "R2";
      check(t, qa, m_qa);
      check((m_mode == 0) ? "R3" : t, {qd, qc, qb}, m_c5);
      check("R6", tc, m_tc);
      if (tc) tc_seen++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [1:0] md);
    @(negedge clk); rst_ni = 1'b0; mode = md;
    tick(3); rst_ni = 1'b1; tc_seen = 0;
  endtask

  // sel bit0 drives A, bit1 drives B
  task automatic pulse(int sel, int lo, int hi);
    @(negedge clk);
    if (sel[0]) cnt_a = 1'b0;
    if (sel[1]) cnt_b = 1'b0;
    tick(lo);
    if (sel[0]) cnt_a = 1'b1;
    if (sel[1]) cnt_b = 1'b1;
    tick(hi);
  endtask

  initial begin
    tick(2);
    check("R1", {qa, qb, qc, qd, tc}, 0);
    // R1: pulses under reset do nothing
    for (int i = 0; i < 4; i++) pulse(3, 1, 2);
    check("R1", {qa, qb, qc, qd, tc}, 0);
    rst_ni = 1'b1;
    tick(4);
    check("R1", {qa, qb, qc, qd}, 0);

    // split mode: R2 and R3
    do_reset(2'b00);
    for (int i = 0; i < 7; i++) pulse(1, 1 + i % 3, 2);
    for (int i = 0; i < 13; i++) pulse(2, 2, 1 + i % 4);
    tick(4);
    check("R2", qa, 1);
    check("R3", {qd, qc, qb}, 3);
    for (int i = 0; i < 6; i++) pulse(3, 1, 1);
    tick(4);
    check("R2", qa, 1);
    check("R3", {qd, qc, qb}, 4);
    check("R6", tc_seen, 0);

    // decimal mode: R4, R6
    do_reset(2'b01);
    for (int i = 0; i < 9; i++) pulse(1, 2, 2);
    tick(4);
    check("R4", {qd, qc, qb, qa}, 9);
    pulse(3, 2, 2);
    tick(4);
    check("R4", {qd, qc, qb, qa}, 0);
    check("R6", tc_seen, 1);
    for (int i = 0; i < 3; i++) pulse(2, 1, 2); // B ignored
    for (int i = 0; i < 3; i++) pulse(1, 1, 3);
    tick(4);
    check("R4", {qd, qc, qb, qa}, 3);

    // two-five mode: R5, R6
    do_reset(2'b10);
    for (int i = 0; i < 7; i++) pulse(2, 1 + i % 2, 2);
    tick(4);
    check("R5", {qa, qd, qc, qb}, 4'b1010);
    for (int i = 0; i < 3; i++) pulse(1, 2, 2); // A ignored
    for (int i = 0; i < 3; i++) pulse(2, 2, 2);
    tick(4);
    check("R5", {qa, qd, qc, qb}, 0);
    check("R6", tc_seen, 1);
    for (int i = 0; i < 20; i++) pulse(2, 1, 1);
    tick(4);
    check("R6", tc_seen, 3);

    // R7: code 11 behaves as split
    do_reset(2'b11);
    for (int i = 0; i < 3; i++) pulse(1, 1, 1);
    for (int i = 0; i < 6; i++) pulse(2, 1, 1);
    tick(4);
    check("R7", {qd, qc, qb, qa}, 4'b0011);
    check("R7", tc_seen, 0);

    // R8: mode change after capture ignored
    do_reset(2'b01);
    tick(2); mode = 2'b10;
    for (int i = 0; i < 3; i++) pulse(1, 1, 2);
    tick(4);
    check("R8", {qd, qc, qb, qa}, 3);

    // R9: low level at reset release not counted
    @(negedge clk); cnt_a = 1'b0; cnt_b = 1'b0;
    do_reset(2'b00);
    tick(6);
    check("R9", {qd, qc, qb, qa}, 0);
    @(negedge clk); cnt_a = 1'b1; cnt_b = 1'b1;
    tick(2);
    pulse(3, 1, 1);
    tick(4);
    check("R9", {qd, qc, qb, qa}, 4'b0011);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule